// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller

This block arbitrates interrupt requests for a small pipelined processor. Each source is either edge-remembering or condition-following. An edge-remembering source sets a sticky pending bit whenever its input is high. A condition-following source requests service only while its input is high and keeps no memory of the request. A pending request needs its per-source enable and the global enable to be considered. Among the requests that pass, the lowest source index wins. The winner is handed to the processor as an index, and a vector address follows after the entry latency has elapsed.

The processor side is abstracted. An instruction-boundary strobe marks the cycle in which an instruction completes. Three decoded type inputs mark whether that instruction is a return-from-interrupt, a set-global-enable or a clear-global-enable. A sleep input stands in for the boundary while the core is halted. A relocation input moves the whole vector table to an alternate base. The block owns the global enable bit and the one-instruction deferral that follows a return or a set-enable.

Top module: `irq_ctrl`

## Requirements
- R1: Among sources that are pending and enabled, the lowest index is taken. Vector slot 0 is reserved for reset, so source i uses slot i+1.
- R2: A take is a one-cycle pulse on `take_o` together with `take_idx_o`. It appears on the clock edge that ends the qualifying boundary cycle. `gie_o` is low from that same edge onward. After reset, `take_o`, `gie_o` and `vec_fetch_o` are low and no flag is pending.
- R3: An edge-remembering source with input high sets its pending bit. The bit is held while the source enable or the global enable is clear, and it is serviced once both are set.
- R4: A pending bit is cleared by the take of its own index, or by a cycle with `sw_clr_wr_i` high and a one in that bit of `sw_clr_data_i`. A source input that is high in the same cycle as either clear leaves the bit set.
- R5: A condition-following source (a one in `LEVEL_MASK`, bits 6 and 7 by default) requests only while its input is high. A pulse that ends before it is enabled produces no take.
- R6: A boundary where `insn_reti_i` is high sets the global enable. No take occurs at that boundary or at the next instruction boundary.
- R7: A boundary where `insn_sei_i` is high sets the global enable, with the same deferral as R6. A boundary where `insn_cli_i` is high clears the global enable, and no take occurs at that boundary, even for a request that arrives in the same cycle.
- R8: Takes happen only in a cycle with `insn_done_i` or `sleep_i` high. A request waits without a take while the boundary strobe stays low, as it does during a multi-cycle instruction.
- R9: `vec_fetch_o` pulses for one cycle `ENTRY_CLKS` (5) cycles after `take_o`. If `sleep_i` was high in the take decision cycle, the pulse comes `ENTRY_CLKS+SLEEP_EXTRA` (10) cycles after `take_o`.
- R10: `vec_addr_o` equals base + (index+1)·`VEC_STRIDE` (stride 2). The base is `ALT_BASE` (0x7000) when `reloc_i` was high in the take decision cycle, and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_i | input | NUM_SRC | Source event or condition inputs |
| src_en_i | input | NUM_SRC | Per-source enables |
| sw_clr_wr_i | input | 1 | Software write-one-to-clear strobe |
| sw_clr_data_i | input | NUM_SRC | Bits to clear when the strobe is high |
| insn_done_i | input | 1 | An instruction completes this cycle |
| insn_reti_i | input | 1 | The completing instruction is a return-from-interrupt |
| insn_sei_i | input | 1 | The completing instruction sets the global enable |
| insn_cli_i | input | 1 | The completing instruction clears the global enable |
| sleep_i | input | 1 | Core is asleep, so each cycle is a take opportunity |
| reloc_i | input | 1 | Place the vector table at the alternate base |
| gie_o | output | 1 | Global interrupt enable state |
| take_o | output | 1 | One-cycle take pulse |
| take_idx_o | output | IDX_W | Index of the source taken |
| vec_fetch_o | output | 1 | Vector address is ready (one-cycle pulse) |
| vec_addr_o | output | ADDR_W | Vector address |

## Verification
Two pairs of functions can fall in the same cycle. In the first pair, a clear-enable completes in the cycle a new request appears; the bench applies both in one cycle and expects no take, a low global enable, and a take of that source only after the enable is set again. In the second pair, a software clear of one bit meets a fresh event on the same bit; the bench expects the event to survive, so that bit is taken later while a bit cleared without a competing event is never taken. The deferral after a return is judged with a second request already pending, so an early take would be visible.

// File: rtl/irq_pkg.sv
package irq_pkg;

    // Global enable state plus the one-instruction hold-off marker.
    typedef struct packed {
        logic gie;
        logic defer;
    } gate_t;

    function automatic int unsigned idx_bits(int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/irq_src_bank.sv
module irq_src_bank #(
    parameter int                 NUM_SRC    = 8,
    parameter logic [NUM_SRC-1:0] LEVEL_MASK = '0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_i,
    input  logic [NUM_SRC-1:0] en_i,
    input  logic               sw_clr_wr_i,
    input  logic [NUM_SRC-1:0] sw_clr_data_i,
    input  logic [NUM_SRC-1:0] hw_clr_i,
    output logic [NUM_SRC-1:0] req_o
);

    typedef struct packed {
        logic [NUM_SRC-1:0] flag;
    } bank_t;

    bank_t              st_d, st_q;
    logic [NUM_SRC-1:0] clr_mask;
    logic [NUM_SRC-1:0] raw;

    always_comb begin
        clr_mask = hw_clr_i | (sw_clr_wr_i ? sw_clr_data_i : '0);
        st_d     = st_q;
        // A new event beats a clear arriving in the same cycle.
        st_d.flag = ((st_q.flag & ~clr_mask) | src_i) & ~LEVEL_MASK;
        raw       = (st_q.flag & ~LEVEL_MASK) | (src_i & LEVEL_MASK);
        req_o     = raw & en_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
    parameter int NUM_SRC = 8,
    parameter int IDX_W   = 3
) (
    input  logic [NUM_SRC-1:0] req_i,
    output logic               valid_o,
    output logic [IDX_W-1:0]   idx_o
);

    // Scan from the top down so the lowest set index is the last written.
    always_comb begin
        valid_o = 1'b0;
        idx_o   = '0;
        for (int i = NUM_SRC - 1; i >= 0; i--) begin
            if (req_i[i]) begin
                valid_o = 1'b1;
                idx_o   = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq #(
    parameter int IDX_W       = 3,
    parameter int ADDR_W      = 16,
    parameter int ENTRY_CLKS  = 5,
    parameter int SLEEP_EXTRA = 5,
    parameter int VEC_STRIDE  = 2,
    parameter int ALT_BASE    = 'h7000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [IDX_W-1:0]  idx_i,
    input  logic              sleep_i,
    input  logic              reloc_i,
    output logic              busy_o,
    output logic              fetch_o,
    output logic [ADDR_W-1:0] addr_o
);

    localparam int MAX_LAT = ENTRY_CLKS + SLEEP_EXTRA;
    localparam int CNT_W   = $clog2(MAX_LAT + 1);

    typedef struct packed {
        logic [CNT_W-1:0]  cnt;
        logic              busy;
        logic              fetch;
        logic [ADDR_W-1:0] addr;
    } entry_t;

    entry_t            st_d, st_q;
    logic [ADDR_W-1:0] slot;
    logic [ADDR_W-1:0] base;

    always_comb begin
        slot = ADDR_W'(idx_i) + ADDR_W'(1);
        base = reloc_i ? ADDR_W'(ALT_BASE) : '0;

        st_d       = st_q;
        st_d.fetch = 1'b0;
        if (st_q.busy) begin
            if (st_q.cnt == CNT_W'(1)) begin
                st_d.busy  = 1'b0;
                st_d.fetch = 1'b1;
                st_d.cnt   = '0;
            end else begin
                st_d.cnt = st_q.cnt - CNT_W'(1);
            end
        end else if (start_i) begin
            st_d.busy = 1'b1;
            st_d.cnt  = sleep_i ? CNT_W'(MAX_LAT) : CNT_W'(ENTRY_CLKS);
            st_d.addr = base + ADDR_W'(slot * ADDR_W'(VEC_STRIDE));
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy_o  = st_q.busy;
    assign fetch_o = st_q.fetch;
    assign addr_o  = st_q.addr;

endmodule

// File: rtl/irq_ctrl.sv
module irq_ctrl
    import irq_pkg::*;
#(
    parameter int                 NUM_SRC     = 8,
    parameter logic [NUM_SRC-1:0] LEVEL_MASK  = 8'hC0,
    parameter int                 ADDR_W      = 16,
    parameter int                 ENTRY_CLKS  = 5,
    parameter int                 SLEEP_EXTRA = 5,
    parameter int                 VEC_STRIDE  = 2,
    parameter int                 ALT_BASE    = 'h7000,
    localparam int                IDX_W       = idx_bits(NUM_SRC)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_i,
    input  logic [NUM_SRC-1:0] src_en_i,
    input  logic               sw_clr_wr_i,
    input  logic [NUM_SRC-1:0] sw_clr_data_i,
    input  logic               insn_done_i,
    input  logic               insn_reti_i,
    input  logic               insn_sei_i,
    input  logic               insn_cli_i,
    input  logic               sleep_i,
    input  logic               reloc_i,
    output logic               gie_o,
    output logic               take_o,
    output logic [IDX_W-1:0]   take_idx_o,
    output logic               vec_fetch_o,
    output logic [ADDR_W-1:0]  vec_addr_o
);

    typedef struct packed {
        gate_t            gate;
        logic             take;
        logic [IDX_W-1:0] idx;
    } ctrl_t;

    ctrl_t              st_d, st_q;
    logic [NUM_SRC-1:0] req;
    logic [NUM_SRC-1:0] hw_clr;
    logic               pick_valid;
    logic [IDX_W-1:0]   pick_idx;
    logic               entry_busy;
    logic               ctl_insn;
    logic               at_bound;
    logic               grant;

    irq_src_bank #(
        .NUM_SRC    (NUM_SRC),
        .LEVEL_MASK (LEVEL_MASK)
    ) u_bank (
        .clk           (clk),
        .rst_n         (rst_n),
        .src_i         (src_i),
        .en_i          (src_en_i),
        .sw_clr_wr_i   (sw_clr_wr_i),
        .sw_clr_data_i (sw_clr_data_i),
        .hw_clr_i      (hw_clr),
        .req_o         (req)
    );

    irq_prio_pick #(
        .NUM_SRC (NUM_SRC),
        .IDX_W   (IDX_W)
    ) u_pick (
        .req_i   (req),
        .valid_o (pick_valid),
        .idx_o   (pick_idx)
    );

    irq_entry_seq #(
        .IDX_W       (IDX_W),
        .ADDR_W      (ADDR_W),
        .ENTRY_CLKS  (ENTRY_CLKS),
        .SLEEP_EXTRA (SLEEP_EXTRA),
        .VEC_STRIDE  (VEC_STRIDE),
        .ALT_BASE    (ALT_BASE)
    ) u_entry (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (grant),
        .idx_i   (pick_idx),
        .sleep_i (sleep_i),
        .reloc_i (reloc_i),
        .busy_o  (entry_busy),
        .fetch_o (vec_fetch_o),
        .addr_o  (vec_addr_o)
    );

    always_comb begin
        // Enable-changing instructions never take at their own boundary.
        ctl_insn = insn_done_i & (insn_reti_i | insn_sei_i | insn_cli_i);
        at_bound = insn_done_i | sleep_i;
        grant    = pick_valid & at_bound & st_q.gate.gie & ~st_q.gate.defer
                 & ~entry_busy & ~ctl_insn;
        hw_clr   = grant ? (NUM_SRC'(1) << pick_idx) : '0;

        st_d      = st_q;
        st_d.take = grant;
        if (grant) begin
            st_d.idx = pick_idx;
        end

        if (grant) begin
            st_d.gate.gie = 1'b0;
        end else if (insn_done_i) begin
            if (insn_reti_i || insn_sei_i) begin
                st_d.gate.gie = 1'b1;
            end else if (insn_cli_i) begin
                st_d.gate.gie = 1'b0;
            end
        end

        // Deferral lasts until the next instruction completes.
        if (insn_done_i) begin
            st_d.gate.defer = insn_reti_i | insn_sei_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign gie_o      = st_q.gate.gie;
    assign take_o     = st_q.take;
    assign take_idx_o = st_q.idx;

endmodule

// File: rtl/irq_ctrl_chk.sv
module irq_ctrl_chk #(
    parameter int NUM_SRC = 8,
    parameter int IDX_W   = 3
) (
    input logic               clk,
    input logic               rst_n,
    input logic [NUM_SRC-1:0] src_en_i,
    input logic               insn_done_i,
    input logic               insn_reti_i,
    input logic               insn_sei_i,
    input logic               insn_cli_i,
    input logic               sleep_i,
    input logic               gie_o,
    input logic               take_o,
    input logic [IDX_W-1:0]   take_idx_o,
    input logic               vec_fetch_o
);

    logic [NUM_SRC-1:0] idx_oh;

    always_comb idx_oh = NUM_SRC'(1) << take_idx_o;

    AST_TAKE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        take_o |=> !take_o); // R2
    AST_TAKE_DROPS_GIE: assert property (@(posedge clk) disable iff (!rst_n)
        take_o |-> !gie_o); // R2
    AST_TAKE_NEEDS_GIE: assert property (@(posedge clk) disable iff (!rst_n)
        take_o |-> $past(gie_o)); // R2
    AST_WINNER_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
        take_o |-> |($past(src_en_i) & idx_oh)); // R1
    AST_TAKE_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
        take_o |-> $past(insn_done_i || sleep_i)); // R8
    AST_RETI_NO_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
        (insn_done_i && insn_reti_i) |=> !take_o); // R6
    AST_SEI_NO_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
        (insn_done_i && insn_sei_i) |=> !take_o); // R7
    AST_CLI_NO_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
        (insn_done_i && insn_cli_i) |=> (!take_o && !gie_o)); // R7
    AST_FETCH_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        vec_fetch_o |=> !vec_fetch_o); // R9

endmodule

bind irq_ctrl irq_ctrl_chk #(
    .NUM_SRC (NUM_SRC),
    .IDX_W   (IDX_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .src_en_i    (src_en_i),
    .insn_done_i (insn_done_i),
    .insn_reti_i (insn_reti_i),
    .insn_sei_i  (insn_sei_i),
    .insn_cli_i  (insn_cli_i),
    .sleep_i     (sleep_i),
    .gie_o       (gie_o),
    .take_o      (take_o),
    .take_idx_o  (take_idx_o),
    .vec_fetch_o (vec_fetch_o)
);

// File: tb/test_irq_ctrl.sv
module test_irq_ctrl;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [7:0]  src_i, src_en_i, sw_clr_data_i;
    logic        sw_clr_wr_i, insn_done_i, insn_reti_i, insn_sei_i, insn_cli_i;
    logic        sleep_i, reloc_i;
    logic        gie_o, take_o, vec_fetch_o;
    logic [2:0]  take_idx_o;
    logic [15:0] vec_addr_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    irq_ctrl i_irq_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .src_i         (src_i),
        .src_en_i      (src_en_i),
        .sw_clr_wr_i   (sw_clr_wr_i),
        .sw_clr_data_i (sw_clr_data_i),
        .insn_done_i   (insn_done_i),
        .insn_reti_i   (insn_reti_i),
        .insn_sei_i    (insn_sei_i),
        .insn_cli_i    (insn_cli_i),
        .sleep_i       (sleep_i),
        .reloc_i       (reloc_i),
        .gie_o         (gie_o),
        .take_o        (take_o),
        .take_idx_o    (take_idx_o),
        .vec_fetch_o   (vec_fetch_o),
        .vec_addr_o    (vec_addr_o)
    );

    typedef struct packed {
        logic [7:0] en;
        logic [7:0] pulse;
        logic [7:0] hold;
        logic       take;
        logic [2:0] idx;
    } row_t;

    // Sources 6 and 7 follow their condition; 0..5 remember events.
    localparam row_t ROWS [8] = '{
        '{8'hFF, 8'h01, 8'h00, 1'b1, 3'd0},
        '{8'hFF, 8'h24, 8'h00, 1'b1, 3'd2},
        '{8'hFB, 8'h24, 8'h00, 1'b1, 3'd5},
        '{8'h00, 8'hFF, 8'h00, 1'b0, 3'd0},
        '{8'hFF, 8'h00, 8'h80, 1'b1, 3'd7},
        '{8'hC0, 8'h3F, 8'hC0, 1'b1, 3'd6},
        '{8'hFF, 8'h90, 8'h00, 1'b1, 3'd4},
        '{8'h80, 8'h80, 8'h00, 1'b0, 3'd0}
    };

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic sw_clear(logic [7:0] m);
        sw_clr_wr_i   = 1'b1;
        sw_clr_data_i = m;
        step();
        sw_clr_wr_i   = 1'b0;
        sw_clr_data_i = '0;
    endtask

    // Set-enable, then one plain instruction that must not be interrupted.
    task automatic gie_on();
        insn_done_i = 1'b1;
        insn_sei_i  = 1'b1;
        step();
        chk("R7", "take at set-enable", take_o, 0);
        insn_sei_i = 1'b0;
        step();
        chk("R7", "take after set-enable", take_o, 0);
        insn_done_i = 1'b0;
    endtask

    task automatic boundary();
        insn_done_i = 1'b1;
        step();
        insn_done_i = 1'b0;
    endtask

    // Wait for the vector, then return and run one deferred instruction.
    task automatic finish_entry(int lat, logic [15:0] exp_addr);
        repeat (lat - 1) step();
        chk("R9", "fetch early", vec_fetch_o, 0);
        step();
        chk("R9", "fetch", vec_fetch_o, 1);
        chk("R10", "vector address", vec_addr_o, exp_addr);
        insn_done_i = 1'b1;
        insn_reti_i = 1'b1;
        step();
        chk("R6", "take at return", take_o, 0);
        chk("R6", "enable after return", gie_o, 1);
        insn_reti_i = 1'b0;
        step();
        chk("R6", "take after return", take_o, 0);
        insn_done_i = 1'b0;
    endtask

    initial begin
        rst_n = 1'b0;
        src_i = '0; src_en_i = '0; sw_clr_wr_i = 1'b0; sw_clr_data_i = '0;
        insn_done_i = 1'b0; insn_reti_i = 1'b0; insn_sei_i = 1'b0; insn_cli_i = 1'b0;
        sleep_i = 1'b0; reloc_i = 1'b0;
        repeat (3) step();
        rst_n = 1'b1;
        step();
        chk("R2", "reset take", take_o, 0);
        chk("R2", "reset enable", gie_o, 0);
        chk("R2", "reset fetch", vec_fetch_o, 0);

        // Table walk: R1 priority, R3 latching, R5 level behaviour.
        for (int r = 0; r < 8; r++) begin
            sw_clear(8'hFF);
            src_en_i = ROWS[r].en;
            src_i    = ROWS[r].pulse | ROWS[r].hold;
            step();
            src_i = ROWS[r].hold;
            gie_on();
            boundary();
            chk("R1", $sformatf("row %0d take", r), take_o, ROWS[r].take);
            if (ROWS[r].take) begin
                chk("R1", $sformatf("row %0d index", r), take_idx_o, ROWS[r].idx);
                chk("R2", "enable cleared on take", gie_o, 0);
                finish_entry(5, 16'((ROWS[r].idx + 1) * 2));
            end
            src_i = '0;
        end

        // R4: hardware clear on take.
        sw_clear(8'hFF);
        src_en_i = 8'hFF;
        src_i = 8'h08; step(); src_i = '0;
        gie_on();
        boundary();
        chk("R4", "take idx3", take_idx_o, 3);
        finish_entry(5, 16'd8);
        boundary();
        chk("R4", "no retake after hw clear", take_o, 0);

        // R6: return defers one instruction with a second request pending.
        src_i = 8'h06; step(); src_i = '0;
        gie_on();
        boundary();
        chk("R1", "take idx1 first", take_idx_o, 1);
        finish_entry(5, 16'd4);
        boundary();
        chk("R6", "deferred take", take_o, 1);
        chk("R6", "deferred idx", take_idx_o, 2);
        finish_entry(5, 16'd6);

        // R7: clear-enable with a request in the same cycle.
        src_i = 8'h01; insn_done_i = 1'b1; insn_cli_i = 1'b1;
        step();
        chk("R7", "take with clear-enable", take_o, 0);
        chk("R7", "enable after clear-enable", gie_o, 0);
        insn_cli_i = 1'b0; insn_done_i = 1'b0; src_i = '0;
        gie_on();
        boundary();
        chk("R3", "latched take", take_o, 1);
        chk("R3", "latched idx", take_idx_o, 0);
        finish_entry(5, 16'd2);

        // R4: software clear, and event beating a clear in the same cycle.
        insn_done_i = 1'b1; insn_cli_i = 1'b1; step();
        insn_cli_i = 1'b0; insn_done_i = 1'b0;
        src_i = 8'h10; step();
        src_i = 8'h02; sw_clr_wr_i = 1'b1; sw_clr_data_i = 8'h12; step();
        src_i = '0; sw_clr_wr_i = 1'b0; sw_clr_data_i = '0;
        gie_on();
        boundary();
        chk("R4", "event survives clear", take_o, 1);
        chk("R4", "event survives idx", take_idx_o, 1);
        finish_entry(5, 16'd4);
        boundary();
        chk("R4", "sw cleared bit not taken", take_o, 0);

        // R8 wait for boundary, R9 sleep latency.
        src_i = 8'h20; step(); src_i = '0;
        repeat (3) step();
        chk("R8", "no take without boundary", take_o, 0);
        sleep_i = 1'b1; step(); sleep_i = 1'b0;
        chk("R8", "take in sleep", take_o, 1);
        chk("R8", "sleep idx", take_idx_o, 5);
        finish_entry(10, 16'd12);

        // R10 relocation, R5 level request held.
        reloc_i = 1'b1; src_i = 8'h40;
        boundary();
        reloc_i = 1'b0; src_i = '0;
        chk("R5", "level take", take_idx_o, 6);
        finish_entry(5, 16'h700E);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL R8 watchdog actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule